// File: doc/BRIEF.md
# Conversion Result Bank with Accumulation and Chaining

This block receives finished conversion results from a converter, one per cycle at most. Each result is tagged with the channel it came from. A routing table, indexed by channel, decides which of sixteen result registers receives it. A register can add several consecutive results together before it shows them as new data, which gives cheap averaging without help from software. A wait-for-read option protects unread data from being overwritten. When that option is off, an overwrite is recorded in a sticky overrun flag.

Neighbouring registers can be linked into a first-in first-out chain. Results enter at the highest-numbered register of the chain and move down one place per cycle while the slot below is free. Software always reads the lowest-numbered register of the chain and gets results in the order they arrived. Software reads through a one-cycle strobe that carries a register index. The same index drives the read data continuously.

Top module: `adc_result_bank`

## Requirements
- R1: While reset is active and after it is released, every bit of `regValid`, `newEvent` and `overrun` is 0.
- R2: A result on channel c goes to the register named by the 4-bit field `chRoute[4c+3:4c]`. No other register changes.
- R3: When a register completes a result, its `regValid` bit is set at the next clock edge. Its `newEvent` bit is high for exactly that one following cycle.
- R4: The 2-bit field `accCfg[2r+1:2r]` with value k makes register r add k+1 accepted results into a 14-bit sum. The sum becomes valid only after the last of these results. Four full-scale results give 16380.
- R5: After a sum completes, the running sum starts again from zero. The next group therefore does not include the earlier results.
- R6: `rdData` always shows register `rdIdx`. A cycle with `rdStrobe` high clears that register's `regValid` bit at the next edge.
- R7: If `holdEn[r]` is 1 and register r holds valid data that is not being read or moved out in that cycle, an incoming result for r is discarded. In that case the register data stays the same, no partial sum is taken, there is no `newEvent`, and there is no overrun.
- R8: If `holdEn[r]` is 0, completing a result into register r while it holds unread valid data replaces the data and sets `overrun[r]`. That bit stays set until reset.
- R9: `chainEn[n]` = 1 links register n to register n+1. A valid entry moves from n+1 to n in one cycle when n is empty and is not being written or read. The channel is routed to the top register of the chain, and reads of the lowest register return results in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | A conversion result is present this cycle |
| resChan | input | 4 | Channel of the result |
| resData | input | 12 | Result value |
| chRoute | input | 64 | Destination register per channel, 4 bits each |
| accCfg | input | 32 | Additions per register minus one, 2 bits each |
| chainEn | input | 16 | Link register n to register n+1 |
| holdEn | input | 16 | Wait-for-read enable per register |
| rdStrobe | input | 1 | Read register `rdIdx` and clear its valid flag |
| rdIdx | input | 4 | Register index for read data and strobe |
| rdData | output | 14 | Contents of register `rdIdx` |
| regValid | output | 16 | Unread valid data per register |
| newEvent | output | 16 | One-cycle pulse when a register completes a result |
| overrun | output | 16 | Sticky flag: unread data was overwritten |

## Verification
On every cycle, the assertions check these properties:
- a new-data pulse always comes with a valid flag;
- overrun flags never drop;
- a guarded register that is full and untouched raises no pulse;
- a strobed read empties its register;
- a chain step copies the upper register's value exactly.

Some behaviours only show up in the bench scenarios because they depend on value history:
- the sum of four full-scale results and the clearing of the running sum;
- whether the held-off or the overwriting value is the one that survives;
- the order in which chained results reach the head.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  localparam int NREG      = 16;
  localparam int NCH       = 16;
  localparam int RES_W     = 12;
  localparam int ACC_CNT_W = 2;
  localparam int ACC_W     = RES_W + ACC_CNT_W;
  localparam int REG_IDX_W = $clog2(NREG);
  localparam int CH_IDX_W  = $clog2(NCH);

  typedef struct packed {
    logic [NREG-1:0] accept;  // result taken into the running sum
    logic [NREG-1:0] commit;  // running sum completes into the register
    logic [NREG-1:0] shift;   // register n+1 moves down into register n
  } bank_strobe_t;
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import adc_bank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       resValid,
  input  logic [CH_IDX_W-1:0]        resChan,
  input  logic [NCH*REG_IDX_W-1:0]   chRoute,
  input  logic [NREG*ACC_CNT_W-1:0]  accCfg,
  input  logic [NREG-1:0]            chainEn,
  input  logic [NREG-1:0]            holdEn,
  input  logic                       rdStrobe,
  input  logic [REG_IDX_W-1:0]       rdIdx,
  output bank_strobe_t               strobes,
  output logic [NREG-1:0]            regValid,
  output logic [NREG-1:0]            newEvent,
  output logic [NREG-1:0]            overrun
);
  logic [REG_IDX_W-1:0] target;
  logic [NREG-1:0] hit, rdHit, moveOut, occupied;
  logic [NREG-1:0] acceptV, commitV, shiftV;

  // Look up the destination register and decode the write and read targets.
  always_comb begin
    target = '0;
    for (int c = 0; c < NCH; c++)
      if (resChan == CH_IDX_W'(c)) target = chRoute[c*REG_IDX_W +: REG_IDX_W];
    hit   = '0;
    rdHit = '0;
    if (resValid) hit[target] = 1'b1;
    if (rdStrobe) rdHit[rdIdx] = 1'b1;
  end

  assign strobes = '{accept: acceptV, commit: commitV, shift: shiftV};

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [ACC_CNT_W-1:0] accProg;
    logic vld, ev, ovr;

    if (r < NREG - 1) begin : g_link
      assign shiftV[r] = chainEn[r] & ~vld & regValid[r+1] & ~rdHit[r+1] & ~hit[r];
    end else begin : g_end
      assign shiftV[r] = 1'b0;
    end
    if (r > 0) begin : g_out
      assign moveOut[r] = shiftV[r-1];
    end else begin : g_head
      assign moveOut[r] = 1'b0;
    end

    assign occupied[r] = vld & ~moveOut[r] & ~rdHit[r];
    assign acceptV[r]  = hit[r] & ~(holdEn[r] & occupied[r]);
    assign commitV[r]  = acceptV[r] & (accProg == accCfg[r*ACC_CNT_W +: ACC_CNT_W]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        accProg <= '0;
        vld     <= 1'b0;
        ev      <= 1'b0;
        ovr     <= 1'b0;
      end else begin
        if (commitV[r])      accProg <= '0;
        else if (acceptV[r]) accProg <= accProg + 1'b1;
        vld <= commitV[r] | shiftV[r] | occupied[r];
        ev  <= commitV[r];
        if (commitV[r] & occupied[r]) ovr <= 1'b1;
      end
    end

    assign regValid[r] = vld;
    assign newEvent[r] = ev;
    assign overrun[r]  = ovr;

    // R3: a new-data pulse never appears without valid data
    p_event_valid_r3: assert property (@(posedge clk) disable iff (!rstN)
      newEvent[r] |-> regValid[r]);
    // R8: the overrun flag is sticky
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      overrun[r] |=> overrun[r]);
    // R7: a guarded full register that is not touched raises no pulse
    p_hold_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
      (holdEn[r] && regValid[r] && !(rdStrobe && rdIdx == REG_IDX_W'(r)) && !moveOut[r])
      |=> !newEvent[r]);
    // R6: a strobed read empties the register unless new data lands in it
    p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
      (rdStrobe && rdIdx == REG_IDX_W'(r) && !commitV[r] && !shiftV[r]) |=> !regValid[r]);
  end
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import adc_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  bank_strobe_t         strobes,
  input  logic [RES_W-1:0]     resData,
  input  logic [REG_IDX_W-1:0] rdIdx,
  output logic [ACC_W-1:0]     rdData
);
  logic [ACC_W-1:0] resBus [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int SRC = (r < NREG - 1) ? r + 1 : r;
    logic [ACC_W-1:0] part, res, sum;

    assign sum = part + ACC_W'(resData);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        part <= '0;
        res  <= '0;
      end else begin
        if (strobes.commit[r]) begin
          res  <= sum;
          part <= '0;
        end else begin
          if (strobes.accept[r]) part <= sum;
          if (strobes.shift[r])  res  <= resBus[SRC];
        end
      end
    end

    assign resBus[r] = res;

    // R9: a chain step carries the upper register's value unchanged
    p_shift_copies_r9: assert property (@(posedge clk) disable iff (!rstN)
      strobes.shift[r] |=> res == $past(resBus[SRC]));
  end

  assign rdData = resBus[rdIdx];
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_bank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       resValid,
  input  logic [CH_IDX_W-1:0]        resChan,
  input  logic [RES_W-1:0]           resData,
  input  logic [NCH*REG_IDX_W-1:0]   chRoute,
  input  logic [NREG*ACC_CNT_W-1:0]  accCfg,
  input  logic [NREG-1:0]            chainEn,
  input  logic [NREG-1:0]            holdEn,
  input  logic                       rdStrobe,
  input  logic [REG_IDX_W-1:0]       rdIdx,
  output logic [ACC_W-1:0]           rdData,
  output logic [NREG-1:0]            regValid,
  output logic [NREG-1:0]            newEvent,
  output logic [NREG-1:0]            overrun
);
  bank_strobe_t strobes;

  arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan),
    .chRoute(chRoute), .accCfg(accCfg), .chainEn(chainEn), .holdEn(holdEn),
    .rdStrobe(rdStrobe), .rdIdx(rdIdx), .strobes(strobes),
    .regValid(regValid), .newEvent(newEvent), .overrun(overrun)
  );

  arb_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .resData(resData),
    .rdIdx(rdIdx), .rdData(rdData)
  );
endmodule

// File: tb/adc_result_bank_test.sv
`timescale 1ns/1ps
module adc_result_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resValid = 1'b0;
  logic [3:0]  resChan = '0;
  logic [11:0] resData = '0;
  logic [63:0] chRoute;
  logic [31:0] accCfg = '0;
  logic [15:0] chainEn = '0;
  logic [15:0] holdEn = '0;
  logic        rdStrobe = 1'b0;
  logic [3:0]  rdIdx = '0;
  logic [13:0] rdData;
  logic [15:0] regValid, newEvent, overrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [13:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;

  adc_result_bank uut (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resChan(resChan), .resData(resData),
    .chRoute(chRoute), .accCfg(accCfg), .chainEn(chainEn), .holdEn(holdEn),
    .rdStrobe(rdStrobe), .rdIdx(rdIdx), .rdData(rdData),
    .regValid(regValid), .newEvent(newEvent), .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendRes(input logic [3:0] ch, input logic [11:0] val);
    @(posedge clk); #1;
    resValid = 1'b1; resChan = ch; resData = val;
    @(posedge clk); #1;
    resValid = 1'b0;
  endtask

  // Driver: queues the expected read value, then strobes the read.
  task automatic readReg(input logic [3:0] idx, input logic [13:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    rdStrobe = 1'b1; rdIdx = idx;
    @(posedge clk); #1;
    rdStrobe = 1'b0;
  endtask

  // Monitor: compares read data against the scoreboard on every strobed read
  always @(negedge clk) begin
    if (rstN && rdStrobe) begin
      if (expQ.size() == 0) check("R6 unexpected read", 32'(rdData), 32'hFFFF_FFFF);
      else begin
        logic [13:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, 32'(rdData), 32'(e));
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 16; c++) chRoute[c*4 +: 4] = 4'(c);
    chRoute[3*4 +: 4]  = 4'd5;   // R2 routing test
    chRoute[10*4 +: 4] = 4'd12;  // R9 chain tail
    accCfg[6*2 +: 2]   = 2'd3;   // R4: four additions on register 6
    holdEn[8]          = 1'b1;   // R7
    chainEn[10]        = 1'b1;   // R9: chain 10-11-12
    chainEn[11]        = 1'b1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", 32'(regValid), 0);
    @(posedge clk); #1; rstN = 1'b1;
    @(negedge clk);
    check("R1 valid", 32'(regValid), 0);
    check("R1 event", 32'(newEvent), 0);
    check("R1 overrun", 32'(overrun), 0);

    // R2 / R3: routing and event pulse
    sendRes(4'd3, 12'h123);
    @(negedge clk);
    check("R2 routed register valid", 32'(regValid[5]), 1);
    check("R2 source index untouched", 32'(regValid[3]), 0);
    check("R3 event pulse", 32'(newEvent), 32'h0020);
    @(negedge clk);
    check("R3 event one cycle", 32'(newEvent), 0);
    readReg(4'd5, 14'h123, "R6 read data");
    @(negedge clk);
    check("R6 valid cleared", 32'(regValid[5]), 0);

    // R4: four full-scale additions
    repeat (3) sendRes(4'd6, 12'hFFF);
    @(negedge clk);
    check("R4 not valid before last add", 32'(regValid[6]), 0);
    check("R4 no event before last add", 32'(newEvent[6]), 0);
    sendRes(4'd6, 12'hFFF);
    @(negedge clk);
    check("R4 valid after last add", 32'(regValid[6]), 1);
    check("R4 event after last add", 32'(newEvent[6]), 1);
    readReg(4'd6, 14'd16380, "R4 sum");

    // R5: running sum restarts
    sendRes(4'd6, 12'd1); sendRes(4'd6, 12'd2);
    sendRes(4'd6, 12'd3); sendRes(4'd6, 12'd4);
    readReg(4'd6, 14'd10, "R5 fresh sum");

    // R8: overwrite with overrun
    sendRes(4'd7, 12'd5);
    sendRes(4'd7, 12'd9);
    @(negedge clk);
    check("R8 overrun set", 32'(overrun), 32'h0080);
    check("R8 event on overwrite", 32'(newEvent[7]), 1);
    readReg(4'd7, 14'd9, "R8 newer value kept");
    repeat (2) @(negedge clk);
    check("R8 overrun sticky", 32'(overrun), 32'h0080);

    // R7: wait-for-read
    sendRes(4'd8, 12'd5);
    sendRes(4'd8, 12'd9);
    @(negedge clk);
    check("R7 no event when held", 32'(newEvent[8]), 0);
    check("R7 no overrun when held", 32'(overrun[8]), 0);
    check("R7 still valid", 32'(regValid[8]), 1);
    readReg(4'd8, 14'd5, "R7 old value kept");

    // R9: three-deep chain
    sendRes(4'd10, 12'd1);
    sendRes(4'd10, 12'd2);
    sendRes(4'd10, 12'd3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 chain filled", 32'(regValid[12:10]), 32'h7);
    readReg(4'd10, 14'd1, "R9 first out");
    repeat (3) @(posedge clk);
    readReg(4'd10, 14'd2, "R9 second out");
    repeat (3) @(posedge clk);
    readReg(4'd10, 14'd3, "R9 third out");
    @(negedge clk);
    check("R9 chain empty", 32'(regValid[12:10]), 0);
    check("R6 all reads consumed", 32'(expQ.size()), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule